// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block sequences the moves of one DMA channel. Software programs a source address, a destination address, a transfer count and a control word through a simple write port. While the channel is enabled and the count is not zero, the block offers a move on a valid/ready pair. A move carries the read address, the write address and a size code. Each accepted move advances both addresses according to their own modification mode and decrements the count.

The element width can be 1, 2 or 4 bytes, and it sets the address step. Each address side can be incremented, decremented or held. Each side can also be confined to an aligned power-of-two window, so that it wraps like a circular buffer. When the count runs out, a completion flag is raised. In single mode the channel then switches itself off. In continuous mode it restores the count and both start addresses and keeps running. Software clears the completion flag by writing a one to its bit.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset all addresses, the count and every control field are zero, the completion flag is clear and `mv_valid` is low.
- R2: `mv_valid` is high exactly when the enable bit (ctrl bit 0) is set and the count is nonzero. `mv_rd_addr` and `mv_wr_addr` show the current source and destination. `mv_size` shows the width field (ctrl bits 3:2) as 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and width code 3 is treated as 4 bytes.
- R3: On an accepted move each side changes by its mode field: source in ctrl bits 5:4, destination in bits 7:6. Code 1 increments, code 2 decrements, and codes 0 and 3 hold. The step is 1, 2 or 4 bytes, taken from the width.
- R4: When a side's circular bit is set (ctrl bit 8 for source, bit 9 for destination), only the low N address bits change on a move, with N taken from ctrl bits 13:10. The address wraps inside its aligned 2^N-byte window.
- R5: The count drops by one per accepted move. With `mv_valid` high and `mv_ready` low, neither the count nor the addresses change.
- R6: In single mode (ctrl bit 1 = 0) the last move leaves the count at zero and clears the enable bit. The addresses keep their stepped values, and later `mv_ready` pulses move nothing.
- R7: In continuous mode (ctrl bit 1 = 1) the last move reloads the count with its programmed value and returns both addresses to their programmed start values. The enable bit stays set.
- R8: The completion flag (ctrl bit 16) sets on every last move. A control write with bit 16 = 1 clears it, and a control write with bit 16 = 0 leaves it unchanged. If a clear and a last move fall in the same cycle, the flag ends set.
- R9: Write select 0 loads the source, 1 the destination, 2 the count and 3 the control word. An address or count write sets both the start value and the current value. A write has priority over a move update of the same register in the same cycle.
- R10: Without circular mode, addresses wrap modulo 2^32 (incrementing past 0xFFFFFFFC by 4 gives 0; decrementing 0x2 by 4 gives 0xFFFFFFFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Write data |
| mv_valid | output | 1 | Move offered |
| mv_ready | input | 1 | Move accepted by the bus side |
| mv_rd_addr | output | 32 | Current source (read) address |
| mv_wr_addr | output | 32 | Current destination (write) address |
| mv_size | output | 2 | Size code: 0 byte, 1 halfword, 2 word |
| cnt_rd | output | 16 | Current remaining count |
| ctrl_rd | output | 32 | Control fields and completion flag (bit 16) |

## Verification
Two pairs of events can land in the same cycle. The first is the completion flag being set by a last move while software writes a one to clear it. The second is a software write to an address register while a move steps that same register. The bench raises `mv_ready` and `cfg_we` on the same clock edge, once on the final move of a continuous transaction and once on an ordinary move. It then requires the flag to stay set in the first case and to clear in the second. It also requires a source written during a move to take the written value, not the stepped one, and to become the new restart point.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    AM_HOLD  = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD3 = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] win_log2;
    logic       dst_circ;
    logic       src_circ;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    logic [1:0] width;
    logic       cont;
    logic       en;
  } chan_cfg_t;

  localparam int CFG_BITS = $bits(chan_cfg_t);
  localparam int DONE_BIT = 16;

  function automatic logic [2:0] step_bytes(input logic [1:0] w);
    case (w)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [1:0] w);
    size_code = (w == 2'd3) ? 2'd2 : w;
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              fire,
  input  logic              restart,
  input  addr_mode_e        mode,
  input  logic [1:0]        width,
  input  logic              circ,
  input  logic [WIN_W-1:0]  win_log2,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] start_q, start_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] raw;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] stepped;

  always_comb begin
    step     = ADDR_W'(step_bytes(width));
    win_mask = (ADDR_W'(1) << win_log2) - ADDR_W'(1);
    case (mode)
      AM_INC:  raw = cur_q + step;
      AM_DEC:  raw = cur_q - step;
      default: raw = cur_q;
    endcase
    stepped = circ ? ((cur_q & ~win_mask) | (raw & win_mask)) : raw;
  end

  always_comb begin
    start_n = start_q;
    cur_n   = cur_q;
    if (load) begin
      start_n = load_val;
      cur_n   = load_val;
    end else if (fire) begin
      cur_n = restart ? start_q : stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
    end else begin
      if (load) start_q <= start_n;
      if (load || fire) cur_q <= cur_n;
    end
  end

  assign addr = cur_q;

  // R3: a plain increment moves by the element step
  a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && !restart && !circ && mode == AM_INC)
      |=> addr == $past(addr) + $past(step));

  // R4: circular side keeps the bits above the window
  a_r4_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && !restart && circ)
      |=> (addr & ~$past(win_mask)) == ($past(addr) & ~$past(win_mask)));

  // R5: no acceptance and no write, no change
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !load) |=> $stable(addr));

  // R7: restart returns to the start value
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && restart && !load) |=> addr == $past(start_q));

  // R9: a write beats a concurrent step
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_val));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             fire,
  input  logic             cont,
  output logic [CNT_W-1:0] count,
  output logic             is_last
);

  logic [CNT_W-1:0] shadow_q, shadow_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign is_last = (cnt_q == CNT_W'(1));

  always_comb begin
    shadow_n = shadow_q;
    cnt_n    = cnt_q;
    if (load) begin
      shadow_n = load_val;
      cnt_n    = load_val;
    end else if (fire) begin
      if (is_last && cont) cnt_n = shadow_q;
      else                 cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (load) shadow_q <= shadow_n;
      if (load || fire) cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

  // R5: one per accepted move
  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

  // R5: held while not accepted
  a_r5_count_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !load) |=> $stable(count));

  // R6: single mode ends at zero
  a_r6_single_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && is_last && !cont) |=> count == '0);

  // R7: continuous mode reloads
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && is_last && cont) |=> count == $past(shadow_q));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_BITS-1:0] wr_fields,
  input  logic                wr_clr_done,
  input  logic                last_move,
  output chan_cfg_t           cfg,
  output logic                done
);

  chan_cfg_t cfg_q, cfg_n;
  logic      done_q, done_n;

  always_comb begin
    cfg_n  = cfg_q;
    done_n = done_q;
    if (wr_en) begin
      cfg_n = chan_cfg_t'(wr_fields);
      if (wr_clr_done) done_n = 1'b0;
    end
    if (last_move) begin
      done_n = 1'b1;
      if (!cfg_q.cont) cfg_n.en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_en || last_move) begin
        cfg_q  <= cfg_n;
        done_q <= done_n;
      end
    end
  end

  assign cfg  = cfg_q;
  assign done = done_q;

  // R8: completion sets the flag even against a clear
  a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    last_move |=> done);

  // R8: only a W1C write clears the flag
  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !done) |-> $past(wr_en && wr_clr_done));

  // R6: single mode switches the channel off
  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (last_move && !cfg.cont) |=> !cfg.en);

  // R7: continuous mode stays on unless rewritten
  a_r7_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
    (last_move && cfg.cont && cfg.en && !wr_en) |=> cfg.en);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [ADDR_W-1:0] mv_rd_addr,
  output logic [ADDR_W-1:0] mv_wr_addr,
  output logic [1:0]        mv_size,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [31:0]       ctrl_rd
);

  localparam int PAD_W = DONE_BIT - CFG_BITS;

  logic       rst_s1, rst_sync_n;
  logic       wdata_unused;
  logic       wr_src, wr_dst, wr_cnt, wr_ctrl;
  logic       fire, cnt_last, last_move, restart;
  chan_cfg_t  cfg;
  logic       done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign wdata_unused = ^cfg_wdata;

  always_comb begin
    wr_src  = cfg_we && (reg_sel_e'(cfg_sel) == SEL_SRC);
    wr_dst  = cfg_we && (reg_sel_e'(cfg_sel) == SEL_DST);
    wr_cnt  = cfg_we && (reg_sel_e'(cfg_sel) == SEL_CNT);
    wr_ctrl = cfg_we && (reg_sel_e'(cfg_sel) == SEL_CTRL);
  end

  assign mv_valid  = cfg.en && (cnt_rd != '0);
  assign fire      = mv_valid && mv_ready;
  assign last_move = fire && cnt_last;
  assign restart   = last_move && cfg.cont;
  assign mv_size   = size_code(cfg.width);

  dma_ctrl_regs u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_ctrl),
    .wr_fields   (cfg_wdata[CFG_BITS-1:0]),
    .wr_clr_done (cfg_wdata[DONE_BIT]),
    .last_move   (last_move),
    .cfg         (cfg),
    .done        (done)
  );

  dma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_cnt),
    .load_val (cfg_wdata[CNT_W-1:0]),
    .fire     (fire),
    .cont     (cfg.cont),
    .count    (cnt_rd),
    .is_last  (cnt_last)
  );

  for (genvar side = 0; side < 2; side++) begin : g_side
    logic              s_load;
    addr_mode_e        s_mode;
    logic              s_circ;
    logic [ADDR_W-1:0] s_addr;
    if (side == 0) begin : g_src
      assign s_load     = wr_src;
      assign s_mode     = cfg.src_mode;
      assign s_circ     = cfg.src_circ;
      assign mv_rd_addr = s_addr;
    end else begin : g_dst
      assign s_load     = wr_dst;
      assign s_mode     = cfg.dst_mode;
      assign s_circ     = cfg.dst_circ;
      assign mv_wr_addr = s_addr;
    end
    dma_addr_unit #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (s_load),
      .load_val (cfg_wdata[ADDR_W-1:0]),
      .fire     (fire),
      .restart  (restart),
      .mode     (s_mode),
      .width    (cfg.width),
      .circ     (s_circ),
      .win_log2 (cfg.win_log2),
      .addr     (s_addr)
    );
  end

  assign ctrl_rd = {{(32-DONE_BIT-1){1'b0}}, done, {PAD_W{1'b0}}, cfg};

  // R2: a move is never offered with nothing left to move
  a_r2_no_empty_offer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mv_valid |-> (cnt_rd != '0 && ctrl_rd[0]));

  // R6: after a single-mode finish nothing is offered
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_move && !cfg.cont && !cfg_we) |=> !mv_valid);

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        mv_valid;
  logic        mv_ready;
  logic [31:0] mv_rd_addr;
  logic [31:0] mv_wr_addr;
  logic [1:0]  mv_size;
  logic [15:0] cnt_rd;
  logic [31:0] ctrl_rd;

  int checks   = 0;
  int failures = 0;

  dma_chan_engine u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .mv_valid   (mv_valid),
    .mv_ready   (mv_ready),
    .mv_rd_addr (mv_rd_addr),
    .mv_wr_addr (mv_wr_addr),
    .mv_size    (mv_size),
    .cnt_rd     (cnt_rd),
    .ctrl_rd    (ctrl_rd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [31:0] DONE_W1C = 32'h1_0000;

  function automatic logic [31:0] mk(input logic en, input logic cont, input logic [1:0] w,
                                     input logic [1:0] sm, input logic [1:0] dm,
                                     input logic sc, input logic dc, input logic [3:0] n);
    mk = {18'd0, n, dc, sc, dm, sm, w, cont, en};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go(input int n);
    @(negedge clk);
    mv_ready = 1'b1;
    repeat (n) @(negedge clk);
    mv_ready = 1'b0;
  endtask

  task automatic go_with_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    mv_ready = 1'b1; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    mv_ready = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c,
                       input logic [31:0] ctrl);
    wr(2'd3, DONE_W1C);
    wr(2'd0, s);
    wr(2'd1, d);
    wr(2'd2, {16'd0, c});
    wr(2'd3, ctrl | DONE_W1C);
  endtask

  task automatic t_reset();
    chk({31'd0, mv_valid}, 32'd0, "R1 valid after reset");
    chk({16'd0, cnt_rd}, 32'd0, "R1 count after reset");
    chk(ctrl_rd, 32'd0, "R1 ctrl after reset");
    chk(mv_rd_addr, 32'd0, "R1 src after reset");
    chk(mv_wr_addr, 32'd0, "R1 dst after reset");
  endtask

  task automatic t_single_word();
    setup(32'h1000, 32'h2000, 16'd3, mk(1, 0, 2'd2, 2'd1, 2'd1, 0, 0, 4'd0));
    chk({31'd0, mv_valid}, 32'd1, "R2 valid when armed");
    chk({30'd0, mv_size}, 32'd2, "R2 size word");
    chk(mv_rd_addr, 32'h1000, "R2 read addr");
    repeat (2) @(negedge clk);
    chk(mv_rd_addr, 32'h1000, "R5 stall keeps src");
    chk({16'd0, cnt_rd}, 32'd3, "R5 stall keeps count");
    go(1);
    chk(mv_rd_addr, 32'h1004, "R3 src inc by 4");
    chk(mv_wr_addr, 32'h2004, "R3 dst inc by 4");
    chk({16'd0, cnt_rd}, 32'd2, "R5 count dec");
    go(2);
    chk({16'd0, cnt_rd}, 32'd0, "R6 count zero");
    chk({31'd0, ctrl_rd[0]}, 32'd0, "R6 enable cleared");
    chk({31'd0, mv_valid}, 32'd0, "R6 valid low");
    chk({31'd0, ctrl_rd[16]}, 32'd1, "R8 done set");
    chk(mv_rd_addr, 32'h100C, "R6 src stays stepped");
    go(2);
    chk(mv_rd_addr, 32'h100C, "R6 ready ignored after finish");
    wr(2'd3, 32'd0);
    chk({31'd0, ctrl_rd[16]}, 32'd1, "R8 write zero keeps done");
    wr(2'd3, DONE_W1C);
    chk({31'd0, ctrl_rd[16]}, 32'd0, "R8 W1C clears done");
  endtask

  task automatic t_modes();
    setup(32'h500, 32'h40, 16'd2, mk(1, 0, 2'd1, 2'd2, 2'd0, 0, 0, 4'd0));
    chk({30'd0, mv_size}, 32'd1, "R2 size half");
    go(1);
    chk(mv_rd_addr, 32'h4FE, "R3 src dec by 2");
    chk(mv_wr_addr, 32'h40, "R3 dst hold");
    setup(32'h10, 32'h20, 16'd2, mk(1, 0, 2'd0, 2'd1, 2'd3, 0, 0, 4'd0));
    chk({30'd0, mv_size}, 32'd0, "R2 size byte");
    go(1);
    chk(mv_rd_addr, 32'h11, "R3 src inc by 1");
    chk(mv_wr_addr, 32'h20, "R3 mode 3 holds");
    setup(32'h0, 32'h0, 16'd0, mk(1, 0, 2'd3, 2'd1, 2'd1, 0, 0, 4'd0));
    chk({31'd0, mv_valid}, 32'd0, "R2 enabled with zero count not valid");
    chk({30'd0, mv_size}, 32'd2, "R2 width code 3 is word");
  endtask

  task automatic t_circular();
    setup(32'h1F8, 32'h300, 16'd2, mk(1, 0, 2'd2, 2'd1, 2'd2, 1, 1, 4'd4));
    go(1);
    chk(mv_rd_addr, 32'h1FC, "R4 src inside window");
    chk(mv_wr_addr, 32'h30C, "R4 dst wraps down");
    go(1);
    chk(mv_rd_addr, 32'h1F0, "R4 src wraps up");
    chk(mv_wr_addr, 32'h308, "R4 dst continues");
  endtask

  task automatic t_continuous();
    logic [31:0] c;
    c = mk(1, 1, 2'd0, 2'd1, 2'd1, 0, 0, 4'd0);
    setup(32'h100, 32'h200, 16'd2, c);
    go(1);
    chk(mv_rd_addr, 32'h101, "R7 first step");
    go(1);
    chk({16'd0, cnt_rd}, 32'd2, "R7 count reload");
    chk(mv_rd_addr, 32'h100, "R7 src restart");
    chk(mv_wr_addr, 32'h200, "R7 dst restart");
    chk({31'd0, ctrl_rd[0]}, 32'd1, "R7 enable stays");
    chk({31'd0, ctrl_rd[16]}, 32'd1, "R8 done set continuous");
    go(1);
    go_with_wr(2'd3, c | DONE_W1C);
    chk({31'd0, ctrl_rd[16]}, 32'd1, "R8 set beats clear");
    go_with_wr(2'd3, c | DONE_W1C);
    chk({31'd0, ctrl_rd[16]}, 32'd0, "R8 clear with plain move");
  endtask

  task automatic t_write_priority();
    setup(32'h700, 32'h900, 16'd3, mk(1, 1, 2'd2, 2'd1, 2'd1, 0, 0, 4'd0));
    go_with_wr(2'd0, 32'h800);
    chk(mv_rd_addr, 32'h800, "R9 write beats step");
    chk(mv_wr_addr, 32'h904, "R9 other side steps");
    chk({16'd0, cnt_rd}, 32'd2, "R9 count still moves");
    go(2);
    chk(mv_rd_addr, 32'h800, "R9 written value is restart point");
    chk(mv_wr_addr, 32'h900, "R9 dst restart");
  endtask

  task automatic t_wrap32();
    setup(32'hFFFF_FFFC, 32'h2, 16'd1, mk(1, 0, 2'd2, 2'd1, 2'd2, 0, 0, 4'd0));
    go(1);
    chk(mv_rd_addr, 32'h0, "R10 inc wraps");
    chk(mv_wr_addr, 32'hFFFF_FFFE, "R10 dec wraps");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'd0; mv_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_word();
    t_modes();
    t_circular();
    t_continuous();
    t_write_priority();
    t_wrap32();
    summary();
    $finish;
  end

endmodule